// File: doc/BRIEF.md
# Three-Wire Tuner Control Port

This block is the slave end of a three-wire serial link that a host controller uses to program a radio tuner and to read its status. The host frames each transfer with an enable line, clocks bits on a clock line and sends data on a data line. The block answers on an open-drain return line. All three inputs are sampled on a fast on-chip system clock, so the block has no serial-clock domain of its own.

A transfer begins with an 8-bit address, clocked in while the enable line is low. When the enable line rises, that address picks one of three modes. The two write modes shift the following bits into a staging register. The staged word reaches its holding register only when the enable line falls, and the PLL and tuner logic read their settings from the two holding registers. The read mode takes a snapshot of the tuner status at the moment the mode is entered. It then presents that snapshot on the return line one bit per serial clock.

Top module: `ser3w_port`

## Requirements
- R1: The mode is decided by the last 8 bits sampled on rising serial-clock edges while enable is low, taken in arrival order with the first of those 8 bits as the most significant. Earlier bits have no effect.
- R2: Address 8'b0001_0100 selects write mode 1. The bits that follow while enable is high are moved into `wr_word1_o` when enable falls. The first data bit lands in bit 0 and the last of the WR_W bits lands in bit WR_W-1.
- R3: Address 8'b1001_0100 selects write mode 2, with the same bit placement, into `wr_word2_o`. `wr_word1_o` is left unchanged.
- R4: While enable is high, neither holding register changes. The previous values stay in force until enable falls.
- R5: A transfer with any other address changes no holding register and leaves the return line released.
- R6: Address 8'b0101_0100 selects read mode. It captures the word {stereo indicator, signal-detect indicator, 0, lock flag, counter MSB..LSB} when enable rises. Later changes on those inputs do not alter the bits sent out, and no holding register changes.
- R7: In read mode the captured word is sent most significant bit first. `do_low_o`=1 means a 0 bit and `do_low_o`=0 means a 1 bit. The line moves to the next bit after each rising serial-clock edge. Once all bits have been sent, the line is released.
- R8: `do_low_o` is 0 whenever enable is low and whenever a write mode is active.
- R9: Transfers work the same whether the serial clock idles high or low between bits. Data is always taken on the rising edge.
- R10: After reset, both holding registers are zero and the return line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times faster than the shortest serial interval |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Serial enable, asynchronous |
| cl_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data from host, asynchronous |
| st_ind_i | input | 1 | Stereo indicator status bit |
| sd_ind_i | input | 1 | Signal-detect indicator status bit |
| locked_i | input | 1 | Lock flag (1 = locked or detection off) |
| if_count_i | input | CNT_W | Frequency counter value |
| wr_word1_o | output | WR_W | Holding register for write mode 1 |
| wr_word2_o | output | WR_W | Holding register for write mode 2 |
| do_low_o | output | 1 | Return line pull-down (1 = drive low, 0 = released) |

## Verification
On every cycle, the assertions check four things: the return line stays released outside read mode, the holding registers stay frozen while enable is high, each register changes only at the end of its own write mode, and the read output moves only on a serial clock edge. The bench's scenarios are what show the decoding itself: that the three address codes pick the right targets, that bits land in the right positions, that the status snapshot is taken at mode entry, that unknown addresses are ignored, and that both clock idle levels give the same results.

// File: rtl/ser3w_pkg.sv
// Shared types and address codes for the three-wire control port.
// Assumes addresses are compared in arrival order, first bit as MSB.
package ser3w_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_WR1  = 2'd1,
        MODE_WR2  = 2'd2,
        MODE_RD   = 2'd3
    } ser_mode_e;

    localparam logic [7:0] ADDR_WR1 = 8'b0001_0100;
    localparam logic [7:0] ADDR_WR2 = 8'b1001_0100;
    localparam logic [7:0] ADDR_RD  = 8'b0101_0100;

    // Map a received address onto a mode; unknown codes give idle.
    function automatic ser_mode_e decode_addr(input logic [7:0] a);
        case (a)
            ADDR_WR1: decode_addr = MODE_WR1;
            ADDR_WR2: decode_addr = MODE_WR2;
            ADDR_RD:  decode_addr = MODE_RD;
            default:  decode_addr = MODE_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ser3w_sync.sv
// Brings enable, clock and data into the system clock domain through a
// chain of STAGES flops and derives edge pulses for enable and clock.
// Assumes the host holds each level for at least 8 system clocks, so
// no edge is missed and the three lines keep their relative order.
module ser3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    input  logic cl_i,
    input  logic di_i,
    output logic ce_s,
    output logic di_s,
    output logic ce_rise,
    output logic ce_fall,
    output logic cl_rise
);
    // bit 2 = enable, bit 1 = clock, bit 0 = data
    logic [2:0] stage_q [STAGES];
    logic [1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 3'b000;
                    else        stage_q[0] <= {ce_i, cl_i, di_i};
                end
            end else begin : g_next
                // Later flops pass the sample along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 3'b000;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    // Remember last synchronized enable and clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= stage_q[STAGES-1][2:1];
    end

    assign ce_s    = stage_q[STAGES-1][2];
    assign di_s    = stage_q[STAGES-1][0];
    assign ce_rise =  stage_q[STAGES-1][2] & ~prev_q[1];
    assign ce_fall = ~stage_q[STAGES-1][2] &  prev_q[1];
    assign cl_rise =  stage_q[STAGES-1][1] & ~prev_q[0];

endmodule

// File: rtl/ser3w_rx.sv
// Receive side: gathers the address while enable is low, picks the mode
// on the enable rising edge, stages write data and commits it to the
// holding registers on the enable falling edge.
// Assumes synchronized inputs and single-cycle edge pulses.
module ser3w_rx
    import ser3w_pkg::*;
#(
    parameter int WR_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_s,
    input  logic            di_s,
    input  logic            ce_rise,
    input  logic            ce_fall,
    input  logic            cl_rise,
    output ser_mode_e       mode_q,
    output logic [WR_W-1:0] word1_q,
    output logic [WR_W-1:0] word2_q
);
    logic [7:0]      addr_q;
    logic [WR_W-1:0] stage_q;
    logic            wr_active;

    assign wr_active = (mode_q == MODE_WR1) || (mode_q == MODE_WR2);

    // Shift address bits in while enable is low; only the last 8 count
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_q <= 8'h00;
        else if (cl_rise && !ce_s)  addr_q <= {addr_q[6:0], di_s};
    end

    // Mode set on enable rise, cleared on enable fall
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_IDLE;
        else if (ce_rise) mode_q <= decode_addr(addr_q);
        else if (ce_fall) mode_q <= MODE_IDLE;
    end

    // Staging register: first data bit travels down to bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)                              stage_q <= '0;
        else if (ce_rise)                        stage_q <= '0;
        else if (cl_rise && ce_s && wr_active)   stage_q <= {di_s, stage_q[WR_W-1:1]};
    end

    // Commit staged word to the selected holding register at enable fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word1_q <= '0;
            word2_q <= '0;
        end else if (ce_fall) begin
            if (mode_q == MODE_WR1) word1_q <= stage_q;
            if (mode_q == MODE_WR2) word2_q <= stage_q;
        end
    end

endmodule

// File: rtl/ser3w_tx.sv
// Transmit side: snapshots the status word at every enable rise and, in
// read mode, shifts it out MSB first after each serial clock rise.
// Assumes the mode input changes on the same edge as the snapshot.
module ser3w_tx
    import ser3w_pkg::*;
#(
    parameter int CNT_W = 20,
    localparam int RD_W = CNT_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_s,
    input  logic             ce_rise,
    input  logic             cl_rise,
    input  ser_mode_e        mode_q,
    input  logic             st_ind,
    input  logic             sd_ind,
    input  logic             locked,
    input  logic [CNT_W-1:0] count,
    output logic             do_low
);
    logic [RD_W-1:0] out_q;

    // Capture on entry, then shift with ones filling (released line)
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '1;
        else if (ce_rise)
            out_q <= {st_ind, sd_ind, 1'b0, locked, count};
        else if (cl_rise && ce_s && mode_q == MODE_RD)
            out_q <= {out_q[RD_W-2:0], 1'b1};
    end

    assign do_low = (mode_q == MODE_RD) && !out_q[RD_W-1];

endmodule

// File: rtl/ser3w_port.sv
// Top of the three-wire tuner control port: synchronizer, receive path
// with two holding registers, and status transmit path.
// Assumes the system clock runs at least 8 times faster than the
// shortest serial interval.
module ser3w_port
    import ser3w_pkg::*;
#(
    parameter int WR_W        = 24,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             cl_i,
    input  logic             di_i,
    input  logic             st_ind_i,
    input  logic             sd_ind_i,
    input  logic             locked_i,
    input  logic [CNT_W-1:0] if_count_i,
    output logic [WR_W-1:0]  wr_word1_o,
    output logic [WR_W-1:0]  wr_word2_o,
    output logic             do_low_o
);
    logic      ce_s, di_s, ce_rise, ce_fall, cl_rise;
    ser_mode_e mode_q;

    ser3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_i    (ce_i),
        .cl_i    (cl_i),
        .di_i    (di_i),
        .ce_s    (ce_s),
        .di_s    (di_s),
        .ce_rise (ce_rise),
        .ce_fall (ce_fall),
        .cl_rise (cl_rise)
    );

    ser3w_rx #(.WR_W(WR_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .di_s    (di_s),
        .ce_rise (ce_rise),
        .ce_fall (ce_fall),
        .cl_rise (cl_rise),
        .mode_q  (mode_q),
        .word1_q (wr_word1_o),
        .word2_q (wr_word2_o)
    );

    ser3w_tx #(.CNT_W(CNT_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .ce_rise (ce_rise),
        .cl_rise (cl_rise),
        .mode_q  (mode_q),
        .st_ind  (st_ind_i),
        .sd_ind  (sd_ind_i),
        .locked  (locked_i),
        .count   (if_count_i),
        .do_low  (do_low_o)
    );

endmodule

// File: rtl/ser3w_chk.sv
// Cycle-level checks on the control port, bound into the top module.
module ser3w_chk
    import ser3w_pkg::*;
#(
    parameter int WR_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ce_s,
    input logic            cl_rise,
    input ser_mode_e       mode_q,
    input logic [WR_W-1:0] wr_word1_o,
    input logic [WR_W-1:0] wr_word2_o,
    input logic            do_low_o
);
    // R8
    do_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s || mode_q == MODE_WR1 || mode_q == MODE_WR2) |-> !do_low_o);

    // R4
    hold_while_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_s |=> ($stable(wr_word1_o) && $stable(wr_word2_o)));

    // R5
    word1_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_word1_o) |-> $past(mode_q == MODE_WR1));

    // R5
    word2_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_word2_o) |-> $past(mode_q == MODE_WR2));

    // R7
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RD && ce_s && !cl_rise) |=> $stable(do_low_o));

endmodule

bind ser3w_port ser3w_chk #(.WR_W(WR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_s       (ce_s),
    .cl_rise    (cl_rise),
    .mode_q     (mode_q),
    .wr_word1_o (wr_word1_o),
    .wr_word2_o (wr_word2_o),
    .do_low_o   (do_low_o)
);

// File: tb/tb_ser3w_port.sv
module tb_ser3w_port;
    localparam int WR_W  = 24;
    localparam int CNT_W = 20;
    localparam int RD_W  = CNT_W + 4;
    localparam int HALF  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, cl = 1'b0, di = 1'b0;
    logic st_ind = 1'b0, sd_ind = 1'b0, locked = 1'b0;
    logic [CNT_W-1:0] cnt = '0;
    logic [WR_W-1:0] w1, w2;
    logic do_low;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ser3w_port #(.WR_W(WR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
        .st_ind_i(st_ind), .sd_ind_i(sd_ind), .locked_i(locked),
        .if_count_i(cnt), .wr_word1_o(w1), .wr_word2_o(w2), .do_low_o(do_low)
    );

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One serial clock pulse that returns to the idle level
    task automatic pulse(input bit idle_hi);
        cl = ~idle_hi; wait_n(HALF);
        cl = idle_hi;  wait_n(HALF);
    endtask

    // Shift one bit; it is taken on the rising clock edge in both cases
    task automatic send_bit(input bit b, input bit idle_hi);
        di = b;
        wait_n(2);
        pulse(idle_hi);
    endtask

    task automatic send_addr(input logic [7:0] a, input bit idle_hi);
        for (int i = 7; i >= 0; i--) send_bit(a[i], idle_hi);
    endtask

    // Full write-type transfer; checks hold and release mid-frame
    task automatic write_frame(input logic [7:0] a, input logic [WR_W-1:0] d,
                               input bit idle_hi, input string tag);
        logic [WR_W-1:0] o1, o2;
        o1 = w1; o2 = w2;
        ce = 1'b0; cl = idle_hi; wait_n(HALF);
        send_addr(a, idle_hi);
        ce = 1'b1; wait_n(HALF);
        for (int i = 0; i < WR_W; i++) send_bit(d[i], idle_hi);
        wait_n(HALF);
        chk({tag, " R4 hold w1"}, 32'(w1), 32'(o1));
        chk({tag, " R4 hold w2"}, 32'(w2), 32'(o2));
        chk({tag, " R8 released"}, 32'(do_low), 32'd0);
        ce = 1'b0; wait_n(HALF);
    endtask

    task automatic read_frame(input bit idle_hi, output logic [RD_W-1:0] got,
                              output logic after);
        ce = 1'b0; cl = idle_hi; wait_n(HALF);
        send_addr(8'b0101_0100, idle_hi);
        ce = 1'b1; wait_n(HALF);
        // change status after entry: must not alter the snapshot (R6)
        st_ind = ~st_ind; cnt = ~cnt; locked = ~locked;
        for (int i = RD_W - 1; i >= 0; i--) begin
            got[i] = ~do_low;
            pulse(idle_hi);
        end
        after = do_low;
        ce = 1'b0; wait_n(HALF);
    endtask

    task automatic t_reset;
        chk("R10 word1", 32'(w1), 32'd0);
        chk("R10 word2", 32'(w2), 32'd0);
        chk("R10 do", 32'(do_low), 32'd0);
    endtask

    task automatic t_write1;
        write_frame(8'b0001_0100, 24'hA5C31E, 1'b0, "wr1");
        chk("R2 word1 idle-low", 32'(w1), 32'hA5C31E);
        chk("R8 do after CE low", 32'(do_low), 32'd0);
    endtask

    task automatic t_write2;
        write_frame(8'b1001_0100, 24'h3C5A96, 1'b1, "wr2");
        chk("R3 word2", 32'(w2), 32'h3C5A96);
        chk("R3 word1 kept", 32'(w1), 32'hA5C31E);
        chk("R9 idle-high write", 32'(w2), 32'h3C5A96);
    endtask

    task automatic t_unknown;
        write_frame(8'b0001_0101, 24'hFFFFFF, 1'b0, "unk");
        chk("R5 word1", 32'(w1), 32'hA5C31E);
        chk("R5 word2", 32'(w2), 32'h3C5A96);
        chk("R5 do", 32'(do_low), 32'd0);
    endtask

    task automatic t_prefix;
        // junk bits ahead of a valid address: only the last 8 count
        ce = 1'b0; cl = 1'b0; wait_n(HALF);
        send_addr(8'b1110_1011, 1'b0);
        send_addr(8'b1111_1111, 1'b0);
        write_frame(8'b0001_0100, 24'h00F00D, 1'b0, "pre");
        chk("R1 last 8 bits decide", 32'(w1), 32'h00F00D);
    endtask

    task automatic t_read(input bit idle_hi, input logic s, input logic d,
                          input logic l, input logic [CNT_W-1:0] c, input string tag);
        logic [RD_W-1:0] got, exp;
        logic after;
        logic [WR_W-1:0] o1, o2;
        o1 = w1; o2 = w2;
        st_ind = s; sd_ind = d; locked = l; cnt = c;
        exp = {s, d, 1'b0, l, c};
        read_frame(idle_hi, got, after);
        chk({tag, " R6 R7 snapshot"}, 32'(got), 32'(exp));
        chk({tag, " R7 released after last bit"}, 32'(after), 32'd0);
        chk({tag, " R6 word1 kept"}, 32'(w1), 32'(o1));
        chk({tag, " R6 word2 kept"}, 32'(w2), 32'(o2));
        chk({tag, " R8 do after CE low"}, 32'(do_low), 32'd0);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_write1();
        t_write2();
        t_unknown();
        t_read(1'b0, 1'b1, 1'b0, 1'b1, 20'hABCDE, "rd-lo");
        t_read(1'b1, 1'b0, 1'b1, 1'b0, 20'h5A0F3, "rd-hi R9");
        t_prefix();
        write_frame(8'b0001_0100, 24'h800001, 1'b1, "edge");
        chk("R2 bit positions", 32'(w1), 32'h800001);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule